// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small status word that tells software why the device last restarted or came out of sleep. Each restart or wake event arrives as a one-cycle strobe. Each event writes its own subset of flags and leaves the other flags as they were. Software can therefore tell apart causes that one "was reset" bit would merge: power-up, supply droop, watchdog expiry while running or while asleep, interrupt wake, external reset, a reset instruction, and stack overflow or underflow.

Software reads the word on `rd_data`. It writes the word through a single-cycle write strobe. A write can re-arm the cause flags that only events clear (the power-up and supply-droop flags). A write cannot touch the two flags that record watchdog and sleep history. If several strobes land in the same cycle, one fixed priority picks the single action that is applied. Power-up is first, supply droop is second, and any event outranks a software write. The block only records causes. It does not generate any reset.

Top module: `rcs_status`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status word becomes 0x1C: bits 4, 3 and 2 are set, and bits 6, 5, 1 and 0 are clear. Field positions are: bit 0 no-power-on, bit 1 no-brown-out, bit 2 no-sleep, bit 3 no-watchdog, bit 4 no-reset-instruction, bit 5 stack-underflow, bit 6 stack-full, bit 7 reserved.
- R2: A power-on strobe loads 0x1C on the next edge, whatever the previous value and whatever other strobe is present.
- R3: A brown-out strobe clears bit 1 on the next edge and leaves every other bit unchanged.
- R4: An external reset while awake changes no bit. A cycle with no strobe and no write also changes no bit.
- R5: A reset-instruction strobe clears bit 4 and leaves the other bits unchanged.
- R6: A watchdog reset while awake clears bit 3 and sets bit 2.
- R7: A watchdog wake from sleep clears both bit 3 and bit 2.
- R8: An external reset during sleep, or an interrupt wake from sleep, sets bit 3 and clears bit 2.
- R9: A stack-full strobe sets bit 6. A stack-underflow strobe sets bit 5. Neither touches any other bit.
- R10: A write with no event loads bits 6, 5, 4, 1 and 0 from `wr_data`. Bits 3 and 2 keep their value.
- R11: When several strobes are present, only the highest one acts. The order is: power-on, brown-out, external-in-sleep, watchdog-wake, interrupt-wake, watchdog-awake, reset-instruction, stack-full, stack-underflow, external-awake, write.
- R12: Bit 7 always reads 0, even after a write of 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_power_on | input | 1 | Power-up detected |
| ev_brownout | input | 1 | Supply droop reset |
| ev_ext_sleep | input | 1 | External reset while asleep |
| ev_wdt_wake | input | 1 | Watchdog expiry while asleep |
| ev_irq_wake | input | 1 | Interrupt wake from sleep |
| ev_wdt_run | input | 1 | Watchdog expiry while running |
| ev_sw_reset | input | 1 | Reset instruction executed |
| ev_stk_full | input | 1 | Stack overflow reset |
| ev_stk_under | input | 1 | Stack underflow reset |
| ev_ext_run | input | 1 | External reset while running |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write value |
| rd_data | output | 8 | Current status word |

## Verification
The bench walks a chain of events in which each step starts from the flags the previous step left behind. A design that wrote too many bits, for example a brown-out that also cleared the power-on flag, breaks every later expected value. Writes of all ones and all zeros check that the watchdog and sleep flags survive software access and that the reserved bit stays 0. Without that, a write mask that is too wide would let software forge watchdog history. Collision cycles pair neighbouring priorities and pair an event with a write. A reversed or incomplete priority chain would then apply the lower action or merge two of them. A reset in the middle of the run, after the word has been emptied, shows that the initial pattern comes back.

// File: rtl/rcs_pkg.sv
// Shared definitions for the reset cause status register.
// Assumes an 8-bit status word whose field positions are fixed by software.
package rcs_pkg;
    localparam int STAT_W = 8;
    localparam int N_EV   = 11;
    localparam int EV_W   = 4;

    // Event codes; the numeric value is also the arbitration rank (0 wins).
    typedef enum logic [EV_W-1:0] {
        EV_PWRON     = 4'd0,
        EV_BROWN     = 4'd1,
        EV_EXT_SLEEP = 4'd2,
        EV_WDT_WAKE  = 4'd3,
        EV_IRQ_WAKE  = 4'd4,
        EV_WDT_RUN   = 4'd5,
        EV_SW        = 4'd6,
        EV_STK_FULL  = 4'd7,
        EV_STK_UNDER = 4'd8,
        EV_EXT_RUN   = 4'd9,
        EV_WRITE     = 4'd10,
        EV_NONE      = 4'd15
    } ev_e;

    typedef struct packed {
        logic pad;
        logic stk_full;
        logic stk_under;
        logic no_swrst;
        logic no_wdt;
        logic no_sleep;
        logic no_brown;
        logic no_pwron;
    } flags_t;

    localparam logic [STAT_W-1:0] WR_MASK   = 8'h73;
    localparam logic [STAT_W-1:0] INIT_WORD = 8'h1C;
endpackage

// File: rtl/rcs_event_arb.sv
// Fixed-priority picker: reports the lowest-index active request.
// Assumes IDX_W bits can hold N-1.
module rcs_event_arb #(
    parameter int N     = 11,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             vld
);
    // Scan from the lowest rank upward so the last hit is the winner.
    always_comb begin
        idx = '0;
        vld = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
                vld = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rcs_flag_next.sv
// Next-state rule for the cause flags: each event edits its own subset.
// Assumes exactly one event code per cycle (the arbiter guarantees this).
module rcs_flag_next
    import rcs_pkg::*;
(
    input  flags_t             cur,
    input  ev_e                ev,
    input  logic [STAT_W-1:0]  wdata,
    output flags_t             nxt
);
    // Apply the chosen event to the current flags.
    always_comb begin
        nxt = cur;
        unique case (ev)
            EV_PWRON:     nxt = flags_t'(INIT_WORD);
            EV_BROWN:     nxt.no_brown = 1'b0;
            EV_EXT_SLEEP,
            EV_IRQ_WAKE: begin
                nxt.no_wdt   = 1'b1;
                nxt.no_sleep = 1'b0;
            end
            EV_WDT_WAKE: begin
                nxt.no_wdt   = 1'b0;
                nxt.no_sleep = 1'b0;
            end
            EV_WDT_RUN: begin
                nxt.no_wdt   = 1'b0;
                nxt.no_sleep = 1'b1;
            end
            EV_SW:        nxt.no_swrst  = 1'b0;
            EV_STK_FULL:  nxt.stk_full  = 1'b1;
            EV_STK_UNDER: nxt.stk_under = 1'b1;
            EV_WRITE:     nxt = flags_t'((cur & ~WR_MASK) | (wdata & WR_MASK));
            default:      nxt = cur;
        endcase
    end
endmodule

// File: rtl/rcs_status.sv
// Reset cause status register top: ranks the strobes, applies one, holds.
// Assumes strobes are synchronous one-cycle pulses in the clk domain.
module rcs_status
    import rcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_power_on,
    input  logic              ev_brownout,
    input  logic              ev_ext_sleep,
    input  logic              ev_wdt_wake,
    input  logic              ev_irq_wake,
    input  logic              ev_wdt_run,
    input  logic              ev_sw_reset,
    input  logic              ev_stk_full,
    input  logic              ev_stk_under,
    input  logic              ev_ext_run,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] rd_data
);
    logic [N_EV-1:0] req;
    logic [EV_W-1:0] win_idx;
    logic            win_vld;
    ev_e             ev;
    flags_t          flags_q;
    flags_t          flags_d;

    // Request vector in rank order, index 0 highest.
    assign req = {wr_en, ev_ext_run, ev_stk_under, ev_stk_full, ev_sw_reset,
                  ev_wdt_run, ev_irq_wake, ev_wdt_wake, ev_ext_sleep,
                  ev_brownout, ev_power_on};

    rcs_event_arb #(.N(N_EV), .IDX_W(EV_W)) u_arb (
        .req (req),
        .idx (win_idx),
        .vld (win_vld)
    );

    // Translate the winning rank into an event code.
    assign ev = win_vld ? ev_e'(win_idx) : EV_NONE;

    rcs_flag_next u_next (
        .cur   (flags_q),
        .ev    (ev),
        .wdata (wr_data),
        .nxt   (flags_d)
    );

    // Status register with synchronous reset to the power-up pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= flags_t'(INIT_WORD);
        else        flags_q <= flags_d;
    end

    assign rd_data = flags_q;
endmodule

// File: rtl/rcs_status_chk.sv
// Property checker for rcs_status, attached with bind.
module rcs_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_power_on,
    input logic       ev_brownout,
    input logic       ev_ext_sleep,
    input logic       ev_wdt_wake,
    input logic       ev_irq_wake,
    input logic       ev_wdt_run,
    input logic       ev_sw_reset,
    input logic       ev_stk_full,
    input logic       ev_stk_under,
    input logic       ev_ext_run,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data
);
    logic [9:0] evs;
    logic       solo;
    assign evs  = {ev_power_on, ev_brownout, ev_ext_sleep, ev_wdt_wake, ev_irq_wake,
                   ev_wdt_run, ev_sw_reset, ev_stk_full, ev_stk_under, ev_ext_run};
    assign solo = ($countones(evs) == 1) && !wr_en;

    a_r2_pwron_init: assert property (@(posedge clk) disable iff (!rst_n)
        ev_power_on |=> rd_data == 8'h1C);
    a_r3_brown_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_brownout && !ev_power_on) |=> (rd_data == ($past(rd_data) & 8'hFD)));
    a_r4_ext_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && ev_ext_run) |=> $stable(rd_data));
    a_r5_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && ev_sw_reset) |=> (rd_data == ($past(rd_data) & 8'hEF)));
    a_r6_wdt_run: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && ev_wdt_run) |=> rd_data[3:2] == 2'b01);
    a_r7_wdt_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && ev_wdt_wake) |=> rd_data[3:2] == 2'b00);
    a_r8_sleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && (ev_ext_sleep || ev_irq_wake)) |=> rd_data[3:2] == 2'b10);
    a_r9_stk_full: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && ev_stk_full) |=> rd_data[6]);
    a_r10_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && evs == 10'd0) |=> (rd_data[3:2] == $past(rd_data[3:2]) &&
                                     rd_data[6:4] == $past(wr_data[6:4])));
    a_r12_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] == 1'b0);
endmodule

bind rcs_status rcs_status_chk u_chk (.*);

// File: tb/tb_rcs_status.sv
module tb_rcs_status;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] ev = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    int         n_chk = 0;
    int         n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // ev bit order: 9 pwron 8 brown 7 ext_sleep 6 wdt_wake 5 irq_wake
    // 4 wdt_run 3 sw 2 stk_full 1 stk_under 0 ext_run
    rcs_status dut (
        .clk(clk), .rst_n(rst_n),
        .ev_power_on(ev[9]), .ev_brownout(ev[8]), .ev_ext_sleep(ev[7]),
        .ev_wdt_wake(ev[6]), .ev_irq_wake(ev[5]), .ev_wdt_run(ev[4]),
        .ev_sw_reset(ev[3]), .ev_stk_full(ev[2]), .ev_stk_under(ev[1]),
        .ev_ext_run(ev[0]), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    // {req[4:0], ev[9:0], wr_en, wr_data[7:0], expected[7:0]}
    localparam logic [31:0] VEC [N_VEC] = '{
        {5'd5,  10'h008, 1'b0, 8'h00, 8'h0C},  // R5 reset instruction
        {5'd4,  10'h001, 1'b0, 8'h00, 8'h0C},  // R4 external while awake
        {5'd6,  10'h010, 1'b0, 8'h00, 8'h04},  // R6 watchdog awake
        {5'd8,  10'h020, 1'b0, 8'h00, 8'h08},  // R8 interrupt wake
        {5'd7,  10'h040, 1'b0, 8'h00, 8'h00},  // R7 watchdog wake
        {5'd8,  10'h080, 1'b0, 8'h00, 8'h08},  // R8 external in sleep
        {5'd10, 10'h000, 1'b1, 8'hFF, 8'h7B},  // R10 write ones
        {5'd3,  10'h100, 1'b0, 8'h00, 8'h79},  // R3 brown-out
        {5'd10, 10'h000, 1'b1, 8'h00, 8'h08},  // R10 write zeros
        {5'd9,  10'h004, 1'b0, 8'h00, 8'h48},  // R9 stack full
        {5'd9,  10'h002, 1'b0, 8'h00, 8'h68},  // R9 stack underflow
        {5'd2,  10'h200, 1'b0, 8'h00, 8'h1C},  // R2 power-on
        {5'd11, 10'h308, 1'b0, 8'h00, 8'h1C},  // R11 power-on beats all
        {5'd10, 10'h000, 1'b1, 8'h13, 8'h1F},  // R10 partial write
        {5'd11, 10'h108, 1'b0, 8'h00, 8'h1D},  // R11 brown beats sw
        {5'd11, 10'h00C, 1'b0, 8'h00, 8'h0D},  // R11 sw beats stack
        {5'd11, 10'h090, 1'b0, 8'h00, 8'h09},  // R11 ext sleep beats wdt awake
        {5'd11, 10'h020, 1'b1, 8'h40, 8'h09},  // R11 event beats write
        {5'd10, 10'h000, 1'b1, 8'h40, 8'h48},  // R10 write bit 6
        {5'd11, 10'h060, 1'b0, 8'h00, 8'h40},  // R11 wdt wake beats irq
        {5'd12, 10'h000, 1'b1, 8'h80, 8'h00}   // R12 reserved bit stays 0
    };

    task automatic check(input int req, input logic [7:0] exp);
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL R%0d: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check(1, 8'h1C);               // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);
        check(4, 8'h1C);               // R4 idle cycle holds
        for (int i = 0; i < N_VEC; i++) begin
            ev      = VEC[i][26:17];
            wr_en   = VEC[i][16];
            wr_data = VEC[i][15:8];
            @(negedge clk);
            ev = '0; wr_en = 1'b0; wr_data = '0;
            check(int'(VEC[i][31:27]), VEC[i][7:0]);
        end
        repeat (3) @(negedge clk);
        check(4, 8'h00);               // R4 quiet cycles hold
        rst_n = 1'b0;
        ev = 10'h004;                  // R1 reset overrides strobes
        @(negedge clk);
        ev = '0;
        check(1, 8'h1C);
        rst_n = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule